// File: doc/BRIEF.md
# Transmit DMA Request and Frame Splitting Controller

This block connects a demand-mode DMA engine to the byte-wide transmit FIFO of a serial frame transmitter. It watches the FIFO fill level and drives a DMA request with hysteresis. The request rises when the level drops below a programmable low-water mark. It falls once the FIFO reaches its almost-full level.

Every byte the DMA engine delivers is passed on to the FIFO one cycle later. Next to each byte sits a frame-end marker for the serializer. A 16-bit frame length is loaded as two separate bytes, a high half and a low half. Long packets are cut into back-to-back frames of exactly that length. The last, shorter piece of a packet is closed by the DMA terminal-count strobe, which also sets a sticky transfer-complete interrupt flag. The host clears that flag with an acknowledge pulse.

Top module: `txdma_frag_ctrl`

## Requirements
- R1: After reset, `dma_req`, `fifo_wr`, `fifo_eof` and `tx_done_irq` are all 0, and the frame length is 0.
- R2: While enabled and not almost full, if `fifo_level` is below `req_thresh`, `dma_req` is 1 one cycle later.
- R3: If `fifo_level` is at least DEPTH-AF_MARGIN (60 by default), `dma_req` is 0 one cycle later. This takes priority over R2. When the level is between the two marks, `dma_req` keeps its previous value.
- R4: A pulse on `len_hi_we` loads `len_wdata` into frame-length bits 15:8. A pulse on `len_lo_we` loads it into bits 7:0.
- R5: Each byte accepted while enabled (`dma_ack`=1) appears on `fifo_wdata` with `fifo_wr`=1 in the next cycle.
- R6: With a non-zero frame length L, the L-th byte of a frame carries `fifo_eof`=1, and the byte count restarts at zero after it. A packet is therefore split into frames of L bytes.
- R7: A byte accepted with `dma_tc`=1 carries `fifo_eof`=1 even if fewer than L bytes have been sent. The next frame counts from zero.
- R8: With frame length 0 there is no automatic split. Only `dma_tc` ends a frame.
- R9: An accepted byte with `dma_tc`=1 sets `tx_done_irq` in the next cycle. The flag stays set until an `irq_ack` pulse clears it. If set and clear happen in the same cycle, set wins.
- R10: While `enable`=0, `dma_req` is 0 one cycle later. Bytes and `dma_tc` are ignored: there is no FIFO write, no interrupt, and no change to the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable |
| req_thresh | input | 7 | Low-water mark for raising the request |
| fifo_level | input | 7 | Current transmit FIFO byte count (0..64) |
| len_hi_we | input | 1 | Load frame length bits 15:8 |
| len_lo_we | input | 1 | Load frame length bits 7:0 |
| len_wdata | input | 8 | Frame length byte |
| dma_ack | input | 1 | DMA delivers a byte this cycle |
| dma_data | input | 8 | Byte from DMA |
| dma_tc | input | 1 | Terminal count, valid with `dma_ack` |
| irq_ack | input | 1 | Clears the transfer-complete flag |
| dma_req | output | 1 | DMA request |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write byte |
| fifo_eof | output | 1 | Frame-end marker with the written byte |
| tx_done_irq | output | 1 | Sticky transfer-complete flag |

## Verification
The assertions rely on three assumptions about the inputs:
- `dma_tc` has meaning only in a cycle where `dma_ack` is also high.
- `fifo_level` never exceeds the FIFO depth.
- Every input changes only between clock edges.

The bench drives all inputs on the falling edge. It raises `dma_tc` only together with `dma_ack`, and it only gives `fifo_level` values from 0 to 64. This keeps the stimulus inside those assumptions while it walks the request through both hysteresis marks and moves frame boundaries through both the length path and the terminal-count path.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  localparam int unsigned FIFO_DEPTH = 64;
  localparam int unsigned AF_MARGIN  = 4;
  localparam int unsigned LEN_W      = 16;
  localparam int unsigned BYTE_W     = 8;
  typedef logic [LEN_W-1:0] flen_t;
endpackage

// File: rtl/txdma_req_gen.sv
module txdma_req_gen #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned MARGIN = 4,
  parameter int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thresh,
  output logic             req
);
  localparam logic [LVL_W-1:0] AF_LVL = LVL_W'(DEPTH - MARGIN);

  logic req_q, req_d;
  logic at_afull, below_thr;

  always_comb begin
    at_afull  = (level >= AF_LVL);
    below_thr = (level < thresh);
    req_d     = req_q;
    if (!enable)        req_d = 1'b0;
    else if (at_afull)  req_d = 1'b0;
    else if (below_thr) req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req = req_q;

  // R10: disabled keeps request low
  p_req_off_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !req);
  // R3: almost full drops the request
  p_req_drop_afull_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (level >= AF_LVL) |=> !req);
  // R2: below the low-water mark raises the request
  p_req_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && level < thresh && level < AF_LVL) |=> req);
  // R3: hysteresis band holds the previous value
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && level >= thresh && level < AF_LVL) |=> $stable(req));
endmodule

// File: rtl/txdma_frame_cnt.sv
module txdma_frame_cnt
  import txdma_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          len_hi_we,
  input  logic          len_lo_we,
  input  logic [7:0]    len_wdata,
  input  logic          dma_ack,
  input  logic [DW-1:0] dma_data,
  input  logic          dma_tc,
  output logic          wr,
  output logic [DW-1:0] wdata,
  output logic          eof,
  output logic          tc_seen
);
  flen_t         len_q, len_d;
  flen_t         cnt_q, cnt_d, cnt_inc;
  logic          wr_q, eof_q;
  logic [DW-1:0] data_q;
  logic          accept, hit_len, end_frame;

  always_comb begin
    len_d = len_q;
    if (len_hi_we) len_d[15:8] = len_wdata;
    if (len_lo_we) len_d[7:0]  = len_wdata;
    accept    = enable && dma_ack;
    cnt_inc   = cnt_q + flen_t'(1);
    hit_len   = (len_q != '0) && (cnt_inc >= len_q);
    end_frame = accept && (hit_len || dma_tc);
    cnt_d     = cnt_q;
    if (accept) cnt_d = end_frame ? '0 : cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      cnt_q <= '0;
      wr_q  <= 1'b0;
      eof_q <= 1'b0;
    end else begin
      len_q <= len_d;
      cnt_q <= cnt_d;
      wr_q  <= accept;
      eof_q <= end_frame;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (accept) data_q <= dma_data;
  end

  assign wr      = wr_q;
  assign wdata   = data_q;
  assign eof     = eof_q;
  assign tc_seen = accept && dma_tc;

  // R6/R7: a frame-end marker always rides on a written byte
  p_eof_with_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> wr);
  // R7: terminal count closes the frame
  p_tc_ends_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && dma_ack && dma_tc) |=> (wr && eof));
  // R10: nothing is written while disabled
  p_no_wr_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !wr);
  // R5: accepted byte appears with its data
  p_fwd_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && dma_ack) |=> (wr && wdata == $past(dma_data)));
endmodule

// File: rtl/txdma_irq_flag.sv
module txdma_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb flag_d = set | (flag_q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R9: set wins and the flag sticks until acknowledged
  p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);
endmodule

// File: rtl/txdma_frag_ctrl.sv
module txdma_frag_ctrl
  import txdma_pkg::*;
#(
  parameter int unsigned DEPTH  = FIFO_DEPTH,
  parameter int unsigned MARGIN = AF_MARGIN,
  parameter int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [LVL_W-1:0] req_thresh,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             len_hi_we,
  input  logic             len_lo_we,
  input  logic [7:0]       len_wdata,
  input  logic             dma_ack,
  input  logic [7:0]       dma_data,
  input  logic             dma_tc,
  input  logic             irq_ack,
  output logic             dma_req,
  output logic             fifo_wr,
  output logic [7:0]       fifo_wdata,
  output logic             fifo_eof,
  output logic             tx_done_irq
);
  logic tc_seen;

  txdma_req_gen #(.DEPTH(DEPTH), .MARGIN(MARGIN), .LVL_W(LVL_W)) u_req (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .level(fifo_level), .thresh(req_thresh), .req(dma_req)
  );

  txdma_frame_cnt #(.DW(8)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .len_hi_we(len_hi_we), .len_lo_we(len_lo_we), .len_wdata(len_wdata),
    .dma_ack(dma_ack), .dma_data(dma_data), .dma_tc(dma_tc),
    .wr(fifo_wr), .wdata(fifo_wdata), .eof(fifo_eof), .tc_seen(tc_seen)
  );

  txdma_irq_flag u_irq (
    .clk(clk), .rst_n(rst_n), .set(tc_seen), .clr(irq_ack), .flag(tx_done_irq)
  );

  // R10: terminal count while disabled never raises the interrupt
  p_tc_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !tx_done_irq) |=> !tx_done_irq);
endmodule

// File: tb/txdma_frag_ctrl_tb_top.sv
`timescale 1ns/1ps
module txdma_frag_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic [6:0] req_thresh, fifo_level;
  logic       len_hi_we, len_lo_we;
  logic [7:0] len_wdata;
  logic       dma_ack, dma_tc, irq_ack;
  logic [7:0] dma_data;
  logic       dma_req, fifo_wr, fifo_eof, tx_done_irq;
  logic [7:0] fifo_wdata;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  txdma_frag_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .req_thresh(req_thresh),
    .fifo_level(fifo_level), .len_hi_we(len_hi_we), .len_lo_we(len_lo_we),
    .len_wdata(len_wdata), .dma_ack(dma_ack), .dma_data(dma_data),
    .dma_tc(dma_tc), .irq_ack(irq_ack), .dma_req(dma_req), .fifo_wr(fifo_wr),
    .fifo_wdata(fifo_wdata), .fifo_eof(fifo_eof), .tx_done_irq(tx_done_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    dma_ack = 0; dma_tc = 0; irq_ack = 0; len_hi_we = 0; len_lo_we = 0;
  endtask

  task automatic set_len(input int len);
    @(negedge clk);
    len_hi_we = 1; len_wdata = 8'(len >> 8);
    @(negedge clk);
    len_hi_we = 0; len_lo_we = 1; len_wdata = 8'(len);
    @(negedge clk);
    len_lo_we = 0;
  endtask

  // one byte; checks write strobe, data and frame-end marker a cycle later
  task automatic send(input logic [7:0] d, input logic tc, input logic exp_eof,
                      input string tag);
    @(negedge clk);
    dma_ack = 1; dma_data = d; dma_tc = tc;
    step();
    chk({tag, " R5 wr"}, int'(fifo_wr), 1);
    chk({tag, " R5 data"}, int'(fifo_wdata), int'(d));
    chk({tag, " eof"}, int'(fifo_eof), int'(exp_eof));
    @(negedge clk);
    dma_ack = 0; dma_tc = 0;
  endtask

  task automatic t_reset();
    chk("R1 req", int'(dma_req), 0);
    chk("R1 wr", int'(fifo_wr), 0);
    chk("R1 eof", int'(fifo_eof), 0);
    chk("R1 irq", int'(tx_done_irq), 0);
  endtask

  task automatic lvl(input int l, input int exp, input string tag);
    @(negedge clk);
    fifo_level = 7'(l);
    step();
    chk(tag, int'(dma_req), exp);
  endtask

  task automatic t_request();
    req_thresh = 7'd16;
    lvl(10, 1, "R2 below mark raises");
    lvl(30, 1, "R3 band holds high");
    lvl(60, 0, "R3 almost full drops");
    lvl(30, 0, "R3 band holds low");
    lvl(15, 1, "R2 raises again");
    lvl(64, 0, "R3 full drops");
    req_thresh = 7'd63;
    lvl(61, 0, "R3 afull beats threshold");
    lvl(59, 1, "R2 just below afull");
    req_thresh = 7'd16;
  endtask

  task automatic t_split();
    set_len(3);
    send(8'hA1, 0, 0, "R6 b1");
    send(8'hA2, 0, 0, "R6 b2");
    send(8'hA3, 0, 1, "R6 b3 end");
    send(8'hA4, 0, 0, "R6 b4");
    send(8'hA5, 0, 0, "R6 b5");
    send(8'hA6, 0, 1, "R6 b6 end");
  endtask

  task automatic t_tc_irq();
    send(8'h51, 0, 0, "R7 b1");
    send(8'h52, 1, 1, "R7 tc short end");
    chk("R9 irq set", int'(tx_done_irq), 1);
    repeat (3) step();
    chk("R9 irq sticky", int'(tx_done_irq), 1);
    send(8'h53, 0, 0, "R7 restart b1");
    send(8'h54, 0, 0, "R7 restart b2");
    send(8'h55, 0, 1, "R7 restart b3 end");
    @(negedge clk); irq_ack = 1;
    step();
    chk("R9 irq cleared", int'(tx_done_irq), 0);
    @(negedge clk); irq_ack = 1; dma_ack = 1; dma_tc = 1; dma_data = 8'h66;
    step();
    chk("R9 set wins over ack", int'(tx_done_irq), 1);
    chk("R7 tc eof", int'(fifo_eof), 1);
    idle();
    @(negedge clk); irq_ack = 1;
    step();
    idle();
    chk("R9 irq cleared again", int'(tx_done_irq), 0);
  endtask

  task automatic t_hi_len();
    set_len(258);
    for (int i = 1; i <= 258; i++)
      send(8'(i), 0, (i == 258), "R4 hi byte length");
    send(8'h01, 0, 0, "R4 next frame");
    send(8'h02, 1, 1, "R7 close");
    idle(); @(negedge clk); irq_ack = 1; step(); idle();
  endtask

  task automatic t_no_split();
    set_len(0);
    for (int i = 0; i < 20; i++)
      send(8'(i), 0, 0, "R8 no auto split");
    send(8'hEE, 1, 1, "R8 tc ends");
    idle(); @(negedge clk); irq_ack = 1; step(); idle();
  endtask

  task automatic t_disabled();
    set_len(3);
    send(8'hC1, 0, 0, "R10 pre b1");
    fifo_level = 7'd2;
    @(negedge clk);
    enable = 0; dma_ack = 1; dma_tc = 1; dma_data = 8'hDD;
    step();
    chk("R10 req low", int'(dma_req), 0);
    chk("R10 no wr", int'(fifo_wr), 0);
    step();
    chk("R10 no irq", int'(tx_done_irq), 0);
    @(negedge clk);
    dma_ack = 0; dma_tc = 0; enable = 1;
    send(8'hC2, 0, 0, "R10 count kept b2");
    send(8'hC3, 0, 1, "R10 count kept b3 end");
    chk("R10 irq still low", int'(tx_done_irq), 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 0; enable = 0; req_thresh = 7'd16; fifo_level = 7'd40;
    len_hi_we = 0; len_lo_we = 0; len_wdata = 0;
    dma_ack = 0; dma_data = 0; dma_tc = 0; irq_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    @(negedge clk); enable = 1;
    t_request();
    t_split();
    t_tc_irq();
    t_hi_len();
    t_no_split();
    t_disabled();
    finish_run();
  end
endmodule